// File: doc/BRIEF.md
# ADC Conversion and Serial Readout Controller

This block sits on the host side of a 14-bit successive-approximation converter that has a serial output. When a sample is requested, the controller drives the convert-start line low for a programmable number of system cycles. It then releases the line high, and that rising edge starts the conversion. After this the controller waits for the converter to pull its frame signal low. The frame signal is active low and is driven by the converter.

While the frame is low, the controller shifts in one data bit on each falling edge of the receive clock, which the converter supplies. Receive clock, frame and data are asynchronous to the host. Each passes through a two-stage synchroniser before any edge is detected. The receive clock may run continuously or be gated, so only the frame decides which clock edges count.

When the frame goes high again, the captured 14-bit two's-complement word is presented with a one-cycle valid strobe. If no frame arrives within a programmable window after convert-start, the controller raises a one-cycle timeout flag and returns to idle.

Top module: `adc_readout_ctrl`

## Requirements
- R1: After reset, `cnv_o` is 1 and `busy_o`, `smp_vld_o`, `tmo_o` and `smp_o` are all 0.
- R2: A request taken in idle drives `cnv_o` low for exactly `CNV_LO_CYC` cycles and then high. `busy_o` is 1 from the first low cycle of `cnv_o` until the controller returns to idle.
- R3: While the synchronised frame is low, each falling edge of the synchronised receive clock shifts one bit in, MSB first. The first bit received becomes `smp_o[13]`, the sign bit of the two's-complement result.
- R4: Once 14 bits have been captured, any further receive-clock falling edges in the same frame are ignored.
- R5: Receive-clock falling edges while the frame is high have no effect on the captured word, whether the clock runs continuously or is gated.
- R6: If the synchronised frame has not gone low within `TMO_CYC` cycles after the rising edge of `cnv_o`, `tmo_o` pulses for one cycle, `busy_o` falls in that same cycle, and no sample is delivered.
- R7: `req_i` is ignored while `busy_o` is 1. No new convert-start follows a request made during a conversion.
- R8: A frame that ends with fewer than 14 bits returns the controller to idle. It produces neither `smp_vld_o` nor `tmo_o` and leaves `smp_o` unchanged.
- R9: When the frame ends with 14 bits captured, `smp_vld_o` is 1 for exactly one cycle. `busy_o` is 0 in that same cycle.
- R10: `smp_o` changes only in a cycle where `smp_vld_o` is 1, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Sample request, taken only when idle |
| cnv_o | output | 1 | Convert-start; conversion begins on its rising edge |
| busy_o | output | 1 | High from convert-start until the controller is idle again |
| frm_ni | input | 1 | Converter frame, active low, asynchronous |
| rclk_i | input | 1 | Converter receive clock, asynchronous |
| rdat_i | input | 1 | Converter serial data, valid at the receive clock's falling edge |
| smp_o | output | DATA_W | Last delivered two's-complement sample |
| smp_vld_o | output | 1 | One-cycle strobe marking a new sample |
| tmo_o | output | 1 | One-cycle strobe: no frame arrived in time |

## Verification
The bench targets several corner cases, and each one shows a distinct symptom when the design gets it wrong:

- **Extreme codes in the sign bit.** The bench uses 0x2000 and 0x1FFF. A design that shifts LSB first, or drops the first bit, returns a bit-reversed or rotated word.
- **Random data toggling on a continuous clock while the frame is high.** A design that does not qualify capture with the frame shifts in garbage before the real word.
- **Frames with more than 14 clocks.** Without saturation, the trailing bits push the MSBs out of the word.
- **Truncated frames.** A design that delivers on frame end without checking the bit count emits a partial word.
- **Missing frame.** A design that never gives up hangs in the busy state; one with an off-by-one counter flags the timeout a cycle early or late.
- **Request in the middle of a transfer.** A design that does not gate the request starts a second conversion.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CNV,
    ST_WAIT,
    ST_RECV
  } rd_state_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned   W       = 1,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= RST_VAL;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_rd_rx.sv
module adc_rd_rx #(
  parameter int unsigned DATA_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              rclk_i,
  input  logic              dat_i,
  input  logic              frm_low_i,
  output logic [DATA_W-1:0] word_o,
  output logic              full_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic              rclk_d_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] word_q;
  logic              fall, take;

  assign fall   = rclk_d_q & ~rclk_i;
  assign full_o = (cnt_q == CNT_W'(DATA_W));
  // frame qualifies every edge; saturate after DATA_W bits
  assign take   = fall & en_i & frm_low_i & ~full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rclk_d_q <= 1'b1;
    else         rclk_d_q <= rclk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      word_q <= '0;
    end else if (take) begin
      cnt_q  <= cnt_q + 1'b1;
      word_q <= {word_q[DATA_W-2:0], dat_i};
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int unsigned CNV_LO_CYC = 16,
  parameter int unsigned TMO_CYC    = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic frm_low_i,
  input  logic full_i,
  output logic cnv_o,
  output logic busy_o,
  output logic clr_o,
  output logic en_o,
  output logic deliver_o,
  output logic tmo_o
);
  localparam int unsigned LIM  = (TMO_CYC > CNV_LO_CYC) ? TMO_CYC : CNV_LO_CYC;
  localparam int unsigned CW   = $clog2(LIM + 1);
  localparam logic [CW-1:0] CNV_LAST = CW'(CNV_LO_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

  rd_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic tmo_q, tmo_set;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q + 1'b1;
    clr_o     = 1'b0;
    deliver_o = 1'b0;
    tmo_set   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_i) begin
          st_d  = ST_CNV;
          clr_o = 1'b1;
        end
      end
      ST_CNV: begin
        if (cnt_q == CNV_LAST) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end
      end
      ST_WAIT: begin
        if (frm_low_i) begin
          st_d  = ST_RECV;
          cnt_d = '0;
        end else if (cnt_q == TMO_LAST) begin
          st_d    = ST_IDLE;
          tmo_set = 1'b1;
        end
      end
      ST_RECV: begin
        cnt_d = '0;
        if (!frm_low_i) begin
          st_d      = ST_IDLE;
          deliver_o = full_i;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      tmo_q <= tmo_set;
    end
  end

  assign cnv_o  = (st_q != ST_CNV);
  assign busy_o = (st_q != ST_IDLE);
  assign en_o   = (st_q == ST_WAIT) || (st_q == ST_RECV);
  assign tmo_o  = tmo_q;
endmodule

// File: rtl/adc_readout_ctrl.sv
module adc_readout_ctrl #(
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned SYNC_STG   = 2,
  parameter int unsigned CNV_LO_CYC = 16,
  parameter int unsigned TMO_CYC    = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              cnv_o,
  output logic              busy_o,
  input  logic              frm_ni,
  input  logic              rclk_i,
  input  logic              rdat_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              smp_vld_o,
  output logic              tmo_o
);
  logic [2:0]        sync_q;
  logic              rclk_s, frm_s, dat_s;
  logic              clr, en, full, deliver;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] smp_q;
  logic              vld_q;

  adc_rd_sync #(
    .W      (3),
    .STAGES (SYNC_STG),
    .RST_VAL(3'b110)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rclk_i, frm_ni, rdat_i}),
    .q_o   (sync_q)
  );

  assign {rclk_s, frm_s, dat_s} = sync_q;

  adc_rd_rx #(
    .DATA_W(DATA_W)
  ) i_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr),
    .en_i     (en),
    .rclk_i   (rclk_s),
    .dat_i    (dat_s),
    .frm_low_i(~frm_s),
    .word_o   (word),
    .full_o   (full)
  );

  adc_rd_seq #(
    .CNV_LO_CYC(CNV_LO_CYC),
    .TMO_CYC   (TMO_CYC)
  ) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .frm_low_i(~frm_s),
    .full_i   (full),
    .cnv_o    (cnv_o),
    .busy_o   (busy_o),
    .clr_o    (clr),
    .en_o     (en),
    .deliver_o(deliver),
    .tmo_o    (tmo_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= deliver;
      if (deliver) smp_q <= word;
    end
  end

  assign smp_o     = smp_q;
  assign smp_vld_o = vld_q;
endmodule

// File: rtl/adc_readout_ctrl_chk.sv
module adc_readout_ctrl_chk #(
  parameter int unsigned DATA_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              cnv_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] smp_o,
  input logic              smp_vld_o,
  input logic              tmo_o
);
  a_r2_cnv_low_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnv_o |-> busy_o);

  a_r7_start_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnv_o) |-> (!$past(busy_o) && $past(req_i)));

  a_r9_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |=> !smp_vld_o);

  a_r9_vld_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_o |-> !busy_o);

  a_r6_tmo_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |=> !tmo_o);

  a_r6_tmo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> (!busy_o && !smp_vld_o));

  a_r10_smp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_o |-> $stable(smp_o));
endmodule

bind adc_readout_ctrl adc_readout_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .cnv_o    (cnv_o),
  .busy_o   (busy_o),
  .smp_o    (smp_o),
  .smp_vld_o(smp_vld_o),
  .tmo_o    (tmo_o)
);

// File: tb/test_adc_readout_ctrl.sv
`timescale 1ns/1ps
module test_adc_readout_ctrl;
  localparam int W   = 14;
  localparam int CNV = 4;
  localparam int TMO = 400;
  localparam int H   = 4;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic frm_n = 1'b1, rclk = 1'b1, rdat = 1'b0;
  logic cnv, busy, vld, tmo;
  logic [W-1:0] smp;
  logic cont = 1'b0, xfer_g = 1'b0;
  int checks = 0, errors = 0, cyc = 0;
  logic [W-1:0] exp_smp = '0;

  always #2 clk = ~clk;

  adc_readout_ctrl #(
    .DATA_W(W), .SYNC_STG(2), .CNV_LO_CYC(CNV), .TMO_CYC(TMO)
  ) i_adc_readout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cnv_o(cnv), .busy_o(busy),
    .frm_ni(frm_n), .rclk_i(rclk), .rdat_i(rdat),
    .smp_o(smp), .smp_vld_o(vld), .tmo_o(tmo)
  );

  // converter receive clock model: continuous or gated
  always begin
    repeat (H) @(negedge clk);
    if (cont || xfer_g) rclk = ~rclk;
    else                rclk = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // request, then check convert-start low width and busy (R2)
  task automatic start_cnv();
    int n;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk(busy == 1'b1, "R2 busy at convert-start", busy, 1);
    n = 0;
    while (!cnv && n < 100) begin n++; @(negedge clk); end
    chk(n == CNV, "R2 convert-start low width", n, CNV);
  endtask

  task automatic convert(input logic [W-1:0] word, input int nbits,
                         input bit mode, input bit mid_req);
    int n;
    cont = mode;
    start_cnv();
    if (!mode) xfer_g = 1'b1;
    repeat (2 + int'($urandom % 2)) begin @(posedge rclk); rdat = 1'($urandom); end
    @(posedge rclk);
    frm_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) @(posedge rclk);
      rdat = (i < W) ? word[W-1-i] : 1'($urandom);
      if (mid_req && i == 5) begin
        chk(busy == 1'b1, "R2 busy during frame", busy, 1);
        @(negedge clk); req = 1'b1;
        @(negedge clk); req = 1'b0;
      end
    end
    @(posedge rclk);
    frm_n  = 1'b1;
    xfer_g = 1'b0;
    rdat   = 1'($urandom);
    n = 0;
    while (!vld && n < 60) begin @(negedge clk); n++; end
    if (nbits >= W) begin
      chk(vld == 1'b1, "R9 valid strobe seen", vld, 1);
      chk(smp == word, (nbits > W) ? "R4 word with extra clocks" :
                       (mode ? "R5 word with continuous clock" : "R3 word MSB first"),
          smp, word);
      chk(busy == 1'b0, "R9 busy low with valid", busy, 0);
      exp_smp = word;
      @(negedge clk);
      chk(vld == 1'b0, "R9 valid one cycle", vld, 0);
    end else begin
      chk(vld == 1'b0, "R8 no valid on short frame", vld, 0);
      chk(busy == 1'b0, "R8 idle after short frame", busy, 0);
      chk(smp == exp_smp, "R8 sample unchanged", smp, exp_smp);
    end
    if (mid_req) begin
      n = 0;
      repeat (20) begin @(negedge clk); if (!cnv || busy) n++; end
      chk(n == 0, "R7 request during conversion ignored", n, 0);
    end
    repeat (10) @(negedge clk);
    chk(smp == exp_smp, "R10 sample held", smp, exp_smp);
  endtask

  initial begin
    int n;
    void'($urandom(32'h5eed_0a7c));
    repeat (3) @(negedge clk);
    chk(cnv == 1'b1 && busy == 1'b0 && vld == 1'b0 && tmo == 1'b0 && smp == '0,
        "R1 reset state", {cnv, busy, vld, tmo}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    convert(14'h2000, W, 1'b0, 1'b0);
    convert(14'h1FFF, W, 1'b0, 1'b0);
    convert(14'h0000, W, 1'b1, 1'b0);
    convert(14'h3FFF, W, 1'b1, 1'b0);
    convert(14'h2A55, W + 3, 1'b0, 1'b0);
    convert(14'h1234, W + 2, 1'b1, 1'b0);
    convert(14'h0F0F, 9, 1'b0, 1'b0);
    convert(14'h3333, W - 1, 1'b1, 1'b0);
    convert(14'h15A5, W, 1'b1, 1'b1);

    // timeout: no frame at all (R6)
    cont = 1'b1;
    start_cnv();
    n = 0;
    while (!tmo && n < TMO + 50) begin @(negedge clk); n++; end
    chk(n == TMO, "R6 timeout delay", n, TMO);
    chk(busy == 1'b0 && vld == 1'b0, "R6 idle without sample", {busy, vld}, 0);
    @(negedge clk);
    chk(tmo == 1'b0, "R6 timeout one cycle", tmo, 0);

    for (int k = 0; k < 20; k++) begin
      int nb;
      nb = (k % 5 == 0) ? W + 1 + int'($urandom % 4) : W;
      convert(W'($urandom), nb, 1'($urandom), (k % 7 == 3));
    end

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule